// File: doc/BRIEF.md
# AXI4-to-AXI3 Write ID Bridge

This block joins an AXI4 write master to an AXI3 write slave port. AXI3 expects a write-data ID on every data beat, and AXI4 carries none. The bridge creates that ID instead of tying it to a constant. A constant would make every outstanding write look like a single transaction to the slave.

The write address, write data and write response channels pass straight through. On each write address handshake toward the slave, the bridge stores the address ID in an in-order queue. The queue depth is set by the master's write issuing capability. An AXI4 master never interleaves write data, so every data beat belongs to the oldest write whose last beat has not yet gone out. The head of the queue is therefore the correct write-data ID.

The head entry is removed when the beat carrying the last flag is accepted. While the queue is empty, write data is held back, because its ID is not yet known. This covers data that arrives before its address. While the queue is full, new addresses are held back. Response IDs exist in both protocol versions, so the response channel is wired through unchanged.

Top module: `axi_wtag_bridge`

## Requirements
- R1: When the ID queue holds fewer than DEPTH entries, the address channel passes through combinationally. dn_awvalid follows up_awvalid, up_awready follows dn_awready, and the ID, address and length are copied unchanged.
- R2: When the queue holds DEPTH entries, dn_awvalid and up_awready are both low, whatever up_awvalid and dn_awready are doing.
- R3: Every forwarded data beat carries, on dn_wid, the address ID of the oldest accepted write whose beat with the last flag has not yet been accepted downstream. The ID stays the same for all beats of one burst.
- R4: While the queue is empty, dn_wvalid and up_wready are low, even if up_wvalid and dn_wready are high. Data presented before its address is not forwarded.
- R5: The head entry is removed only on a data handshake with up_wlast = 1. An address handshake and a last-beat handshake in the same cycle leave the occupancy unchanged.
- R6: The response channel is a pure wire. up_bvalid equals dn_bvalid, dn_bready equals up_bready, and the ID and response code are copied unchanged.
- R7: Reset (rst = 1, synchronous, active high) empties the queue. While rst is high, dn_awvalid, dn_wvalid and up_bvalid are low.
- R8: When a data beat is forwarded, its data, byte strobes and last flag are copied unchanged, and dn_wready is returned as up_wready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_awvalid | input | 1 | Address valid from master |
| up_awready | output | 1 | Address ready to master |
| up_awid | input | ID_W | Address ID from master |
| up_awaddr | input | ADDR_W | Write address from master |
| up_awlen | input | 8 | Burst length (beats minus one) from master |
| dn_awvalid | output | 1 | Address valid to slave |
| dn_awready | input | 1 | Address ready from slave |
| dn_awid | output | ID_W | Address ID to slave |
| dn_awaddr | output | ADDR_W | Write address to slave |
| dn_awlen | output | 8 | Burst length to slave |
| up_wvalid | input | 1 | Data valid from master |
| up_wready | output | 1 | Data ready to master |
| up_wdata | input | DATA_W | Write data from master |
| up_wstrb | input | DATA_W/8 | Byte strobes from master |
| up_wlast | input | 1 | Last beat of burst from master |
| dn_wvalid | output | 1 | Data valid to slave |
| dn_wready | input | 1 | Data ready from slave |
| dn_wid | output | ID_W | Generated write-data ID |
| dn_wdata | output | DATA_W | Write data to slave |
| dn_wstrb | output | DATA_W/8 | Byte strobes to slave |
| dn_wlast | output | 1 | Last beat flag to slave |
| dn_bvalid | input | 1 | Response valid from slave |
| dn_bready | output | 1 | Response ready to slave |
| dn_bid | input | ID_W | Response ID from slave |
| dn_bresp | input | 2 | Response code from slave |
| up_bvalid | output | 1 | Response valid to master |
| up_bready | input | 1 | Response ready from master |
| up_bid | output | ID_W | Response ID to master |
| up_bresp | output | 2 | Response code to master |

## Verification
The bench offers data before any address and checks that nothing leaks through. A bridge that failed here would forward beats tagged with a stale or undefined ID. It fills the queue to exactly DEPTH addresses and checks for the stall. An off-by-one full flag would either drop an ID or stall one write too early. It sweeps bursts of one to four beats under shifting ID patterns and checks the ID on every beat. A bridge that removed entries on the wrong beat would retag the middle of a burst. It also pairs an address acceptance with a last-beat acceptance in the same cycle at DEPTH-1 entries. A bridge that counted this wrongly would stall the next address, or accept one address too many.

// File: rtl/axi_wtag_pkg.sv
package axi_wtag_pkg;
    localparam int LEN_W  = 8;
    localparam int RESP_W = 2;

    typedef enum logic [1:0] {
        QS_EMPTY   = 2'd0,
        QS_PARTIAL = 2'd1,
        QS_FULL    = 2'd2
    } qstate_e;

    function automatic qstate_e classify(input int cnt, input int depth);
        if (cnt == 0)
            return QS_EMPTY;
        else if (cnt >= depth)
            return QS_FULL;
        else
            return QS_PARTIAL;
    endfunction
endpackage

// File: rtl/axi_wtag_idq.sv
module axi_wtag_idq
    import axi_wtag_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output qstate_e         state
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ID_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_id;
    end

    assign head_id = mem[rd_ptr];
    assign state   = classify(int'(count), DEPTH);

    // R2: a push never arrives while the queue is full
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (state != QS_FULL));

    // R4: a pop never arrives while the queue is empty
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> (state != QS_EMPTY));

    // R5: a simultaneous push and pop leaves the fill class alone
    a_r5_simul_keeps: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(state));
endmodule

// File: rtl/axi_wtag_wgate.sv
module axi_wtag_wgate
    import axi_wtag_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  qstate_e             state,
    input  logic [ID_W-1:0]     head_id,
    output logic                pop,
    input  logic                up_wvalid,
    output logic                up_wready,
    input  logic [DATA_W-1:0]   up_wdata,
    input  logic [DATA_W/8-1:0] up_wstrb,
    input  logic                up_wlast,
    output logic                dn_wvalid,
    input  logic                dn_wready,
    output logic [ID_W-1:0]     dn_wid,
    output logic [DATA_W-1:0]   dn_wdata,
    output logic [DATA_W/8-1:0] dn_wstrb,
    output logic                dn_wlast
);
    logic have_id;

    assign have_id   = (state != QS_EMPTY) && !rst;
    assign dn_wvalid = up_wvalid && have_id;
    assign up_wready = dn_wready && have_id;
    assign dn_wid    = head_id;
    assign dn_wdata  = up_wdata;
    assign dn_wstrb  = up_wstrb;
    assign dn_wlast  = up_wlast;
    assign pop       = dn_wvalid && dn_wready && up_wlast;

    // R4: nothing moves on the data channel without a queued ID
    a_r4_gate_empty: assert property (@(posedge clk) disable iff (rst)
        (state == QS_EMPTY) |-> (!dn_wvalid && !up_wready));

    // R3: the tag cannot change under a stalled beat
    a_r3_wid_hold: assert property (@(posedge clk) disable iff (rst)
        (dn_wvalid && !dn_wready) |=> $stable(dn_wid));
endmodule

// File: rtl/axi_wtag_bridge.sv
module axi_wtag_bridge
    import axi_wtag_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                up_awvalid,
    output logic                up_awready,
    input  logic [ID_W-1:0]     up_awid,
    input  logic [ADDR_W-1:0]   up_awaddr,
    input  logic [LEN_W-1:0]    up_awlen,
    output logic                dn_awvalid,
    input  logic                dn_awready,
    output logic [ID_W-1:0]     dn_awid,
    output logic [ADDR_W-1:0]   dn_awaddr,
    output logic [LEN_W-1:0]    dn_awlen,
    input  logic                up_wvalid,
    output logic                up_wready,
    input  logic [DATA_W-1:0]   up_wdata,
    input  logic [DATA_W/8-1:0] up_wstrb,
    input  logic                up_wlast,
    output logic                dn_wvalid,
    input  logic                dn_wready,
    output logic [ID_W-1:0]     dn_wid,
    output logic [DATA_W-1:0]   dn_wdata,
    output logic [DATA_W/8-1:0] dn_wstrb,
    output logic                dn_wlast,
    input  logic                dn_bvalid,
    output logic                dn_bready,
    input  logic [ID_W-1:0]     dn_bid,
    input  logic [RESP_W-1:0]   dn_bresp,
    output logic                up_bvalid,
    input  logic                up_bready,
    output logic [ID_W-1:0]     up_bid,
    output logic [RESP_W-1:0]   up_bresp
);
    qstate_e         q_state;
    logic [ID_W-1:0] q_head;
    logic            aw_open;
    logic            aw_push;
    logic            w_pop;

    assign aw_open    = (q_state != QS_FULL) && !rst;
    assign dn_awvalid = up_awvalid && aw_open;
    assign up_awready = dn_awready && aw_open;
    assign dn_awid    = up_awid;
    assign dn_awaddr  = up_awaddr;
    assign dn_awlen   = up_awlen;
    assign aw_push    = dn_awvalid && dn_awready;

    axi_wtag_idq #(.ID_W(ID_W), .DEPTH(DEPTH)) u_idq (
        .clk     (clk),
        .rst     (rst),
        .push    (aw_push),
        .push_id (up_awid),
        .pop     (w_pop),
        .head_id (q_head),
        .state   (q_state)
    );

    axi_wtag_wgate #(.ID_W(ID_W), .DATA_W(DATA_W)) u_wgate (
        .clk       (clk),
        .rst       (rst),
        .state     (q_state),
        .head_id   (q_head),
        .pop       (w_pop),
        .up_wvalid (up_wvalid),
        .up_wready (up_wready),
        .up_wdata  (up_wdata),
        .up_wstrb  (up_wstrb),
        .up_wlast  (up_wlast),
        .dn_wvalid (dn_wvalid),
        .dn_wready (dn_wready),
        .dn_wid    (dn_wid),
        .dn_wdata  (dn_wdata),
        .dn_wstrb  (dn_wstrb),
        .dn_wlast  (dn_wlast)
    );

    assign up_bvalid = dn_bvalid && !rst;
    assign dn_bready = up_bready;
    assign up_bid    = dn_bid;
    assign up_bresp  = dn_bresp;

    // R2: the slave never sees an address while the queue is full
    a_r2_full_stall: assert property (@(posedge clk) disable iff (rst)
        (q_state == QS_FULL) |-> (!dn_awvalid && !up_awready));

    // R1: the master sees acceptance only when the slave accepts
    a_r1_aw_coherent: assert property (@(posedge clk) disable iff (rst)
        (up_awvalid && up_awready) |-> (dn_awvalid && dn_awready));
endmodule

// File: tb/axi_wtag_bridge_tb.sv
`timescale 1ns/100ps
module axi_wtag_bridge_tb;
    localparam int ID_W = 4, ADDR_W = 32, DATA_W = 32, DEPTH = 8, SW = DATA_W/8;

    logic clk = 1'b0, rst = 1'b1;
    logic up_awvalid = 0, up_awready, dn_awvalid, dn_awready = 0;
    logic [ID_W-1:0] up_awid = 0, dn_awid;
    logic [ADDR_W-1:0] up_awaddr = 0, dn_awaddr;
    logic [7:0] up_awlen = 0, dn_awlen;
    logic up_wvalid = 0, up_wready, up_wlast = 0, dn_wvalid, dn_wready = 0, dn_wlast;
    logic [DATA_W-1:0] up_wdata = 0, dn_wdata;
    logic [SW-1:0] up_wstrb = 0, dn_wstrb;
    logic [ID_W-1:0] dn_wid;
    logic dn_bvalid = 0, dn_bready, up_bvalid, up_bready = 0;
    logic [ID_W-1:0] dn_bid = 0, up_bid;
    logic [1:0] dn_bresp = 0, up_bresp;

    int n_chk = 0, n_fail = 0;
    int mq[$];

    always #2.5 clk = ~clk;

    axi_wtag_bridge u_dut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_aw(input int id, input int beats);
        up_awvalid = 1; up_awid = ID_W'(id);
        up_awaddr = 32'h1000_0000 + 32'(id * 64); up_awlen = 8'(beats - 1);
        dn_awready = 1;
        #1;
        chk(dn_awvalid == 1 && up_awready == 1, "R1 aw pass", {dn_awvalid, up_awready}, 2'b11);
        chk(dn_awid == up_awid && dn_awaddr == up_awaddr && dn_awlen == up_awlen,
            "R1 aw payload", dn_awaddr, up_awaddr);
        tick();
        mq.push_back(id);
        up_awvalid = 0; dn_awready = 0;
    endtask

    task automatic do_w(input int beats, input int tag);
        for (int b = 0; b < beats; b++) begin
            up_wvalid = 1; up_wlast = (b == beats - 1);
            up_wdata = 32'hA000_0000 | 32'(tag << 8) | 32'(b);
            up_wstrb = SW'(4'hF ^ 4'(b)); dn_wready = 1;
            #1;
            chk(dn_wvalid == 1 && up_wready == 1, "R8 w pass", {dn_wvalid, up_wready}, 2'b11);
            chk(int'(dn_wid) == mq[0], "R3 wid", dn_wid, mq[0]);
            chk(dn_wdata == up_wdata && dn_wstrb == up_wstrb && dn_wlast == up_wlast,
                "R8 w payload", dn_wdata, up_wdata);
            tick();
        end
        void'(mq.pop_front());
        up_wvalid = 0; up_wlast = 0; dn_wready = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R7: valids low during reset
        up_awvalid = 1; dn_awready = 1; up_wvalid = 1; dn_wready = 1; dn_bvalid = 1;
        #1;
        chk(dn_awvalid == 0 && dn_wvalid == 0 && up_bvalid == 0, "R7 reset valids",
            {dn_awvalid, dn_wvalid, up_bvalid}, 0);
        tick(); tick();
        up_awvalid = 0; dn_awready = 0; dn_bvalid = 0;
        rst = 0;
        tick();
        // R4 / R7: queue empty after reset, data before address held
        for (int i = 0; i < 3; i++) begin
            #1;
            chk(dn_wvalid == 0 && up_wready == 0, "R4 early data held",
                {dn_wvalid, up_wready}, 0);
            tick();
        end
        up_wvalid = 0; dn_wready = 0;
        // sweep: fill to DEPTH with varied ids, check stall, drain
        for (int pass = 0; pass < 4; pass++) begin
            for (int n = 0; n < DEPTH; n++) do_aw((n * (pass + 3) + pass) % 16, (n + pass) % 4 + 1);
            up_awvalid = 1; dn_awready = 1; up_awid = 4'hF;
            #1;
            chk(dn_awvalid == 0 && up_awready == 0, "R2 full stall", {dn_awvalid, up_awready}, 0);
            tick();
            up_awvalid = 0; dn_awready = 0;
            for (int n = 0; n < DEPTH; n++) do_w((n + pass) % 4 + 1, n);
            up_wvalid = 1; dn_wready = 1;
            #1;
            chk(dn_wvalid == 0 && up_wready == 0, "R4 drained held", {dn_wvalid, up_wready}, 0);
            tick();
            up_wvalid = 0; dn_wready = 0;
        end
        // R5: simultaneous push and pop at DEPTH-1
        for (int n = 0; n < DEPTH - 1; n++) do_aw(n + 2, 1);
        up_awvalid = 1; up_awid = 4'hC; up_awaddr = 32'h2000; up_awlen = 0; dn_awready = 1;
        up_wvalid = 1; up_wlast = 1; up_wdata = 32'h5555; dn_wready = 1;
        #1;
        chk(up_awready == 1 && up_wready == 1, "R5 both accepted", {up_awready, up_wready}, 2'b11);
        chk(int'(dn_wid) == mq[0], "R5 wid", dn_wid, mq[0]);
        tick();
        void'(mq.pop_front()); mq.push_back(12);
        up_awvalid = 0; up_wvalid = 0; up_wlast = 0; dn_awready = 0; dn_wready = 0;
        do_aw(13, 1);
        up_awvalid = 1; dn_awready = 1;
        #1;
        chk(up_awready == 0, "R5 full after swap", up_awready, 0);
        tick();
        up_awvalid = 0; dn_awready = 0;
        for (int n = 0; n < DEPTH; n++) do_w(1, n);
        // R6: response wiring
        for (int k = 0; k < 8; k++) begin
            dn_bvalid = k[0]; up_bready = k[1]; dn_bid = ID_W'(k * 5); dn_bresp = 2'(k);
            #1;
            chk(up_bvalid == dn_bvalid && dn_bready == up_bready && up_bid == dn_bid &&
                up_bresp == dn_bresp, "R6 b pass", {up_bvalid, dn_bready, up_bid, up_bresp},
                {dn_bvalid, up_bready, dn_bid, dn_bresp});
            tick();
        end
        // R7: reset empties queue
        do_aw(7, 1);
        rst = 1; tick(); rst = 0;
        up_wvalid = 1; dn_wready = 1;
        #1;
        chk(dn_wvalid == 0 && up_wready == 0, "R7 queue emptied", {dn_wvalid, up_wready}, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule